// File: doc/BRIEF.md
# Configuration Space Decoder with Timeout

This block sits on the configuration side of a peripheral. It watches a 32-bit request bus for accesses that fall in the 256 MB configuration window, 0xD0000000 up to 0xDFFFFFFF. Inside that window, the address names a bus, a device and a function, and each function owns a 4 kB configuration area. When the address names this block's own slot, the block answers from a small header. The header has a fixed identification word, a command register with a chosen set of writable bits, and one base address register.

Discovery software walks the window and probes one word in every 32 kB step, 8192 probes in all. Most probes land on empty slots. Nothing on the bus answers those, so the block also acts as the fallback responder for the whole window. A short counter, far shorter than an ordinary bus timeout, ends any window access that nobody acknowledges. The block then completes that access itself and returns all ones, which software reads as an absent device.

The request side follows a valid/ready discipline. The requester raises `req_vld` with address, write flag and write data, and holds all of them stable until it sees `rsp_ack`. `rsp_ack` acts as the ready and lasts exactly one cycle. In the cycle after the acknowledge, the requester either drops `req_vld` or presents a new request. Other devices on the configuration bus report their own acknowledge on `ext_ack`.

Top module: `cfg_space_decoder`

## Requirements
- R1: `cfg_sel` is high in exactly the cycles where `req_vld` is high and `req_addr[31:28]` equals 0xD.
- R2: `slot_hit` is high exactly when `cfg_sel` is high and `req_addr[27:20]`, `req_addr[19:15]` and `req_addr[14:12]` equal the bus, device and function parameters.
- R3: A request to the own slot is acknowledged in the cycle after it is first presented. The acknowledge lasts one cycle, and write acknowledges carry read data zero.
- R4: A read of word 0 (`req_addr[11:2]` = 0) returns the device ID in bits 31:16 and the vendor ID in bits 15:0.
- R5: Word 1 returns the command register in bits 15:0 and zero in bits 31:16. Only the bits set in `CMD_WMASK` take write data, and all bits reset to zero.
- R6: Word 4 is the base address register. Bits 31 down to `BAR_LSB` are writable, the bits below `BAR_LSB` read zero, and the register resets to zero.
- R7: Writes to word 0 and to any word other than 1 and 4 change nothing. Every word other than 0, 1 and 4 reads zero.
- R8: A window request that receives no acknowledge is completed by the block `TMO_CYCLES` cycles after it is first presented. The block raises `rsp_ack` for one cycle with `rsp_rdata` equal to 0xFFFFFFFF.
- R9: An `ext_ack` clears the timeout count. A window request answered by another device `TMO_CYCLES`-1 cycles after it was presented produces no acknowledge from this block.
- R10: A write to a slot other than the own slot is acknowledged only by the timeout and leaves the command and base address registers unchanged.
- R11: A request outside the window raises neither `cfg_sel` nor `slot_hit` and is never acknowledged.
- R12: During reset `rsp_ack` is low and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request valid, held until acknowledge |
| req_we | input | 1 | Request is a write |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| ext_ack | input | 1 | Acknowledge from another device on the configuration bus |
| cfg_sel | output | 1 | Request lies in the configuration window |
| slot_hit | output | 1 | Request addresses this block's bus/device/function |
| rsp_ack | output | 1 | One-cycle acknowledge (local answer or timeout) |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ack`, zero otherwise |

## Verification
The bench uses bus 0x5A, device 0x13 and function 5 as the own slot. Each of these values sets both high and low bits in its address field, so a slip of one bit in the slot comparison breaks the match. It keeps the default 16-cycle timeout. It makes an external acknowledge arrive one cycle before the timeout would fire, which checks the exact boundary of the counter. With `CMD_WMASK` at 0x0007 and `BAR_LSB` at 12, writes of all ones read back as masked values that show which bits may be written.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int WORD_W = 10;

  localparam logic [3:0] WINDOW_NIB = 4'hD;

  // header word indices (software decodes these offsets)
  localparam logic [WORD_W-1:0] W_IDENT = 10'd0;
  localparam logic [WORD_W-1:0] W_CMD   = 10'd1;
  localparam logic [WORD_W-1:0] W_BASE  = 10'd4;

  typedef struct packed {
    logic [3:0]        window;
    logic [7:0]        bus;
    logic [4:0]        dev;
    logic [2:0]        func;
    logic [WORD_W-1:0] word;
    logic [1:0]        byte_off;
  } cfg_addr_t;

  function automatic cfg_addr_t split_addr(input logic [ADDR_W-1:0] a);
    return cfg_addr_t'(a);
  endfunction
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfgdec_pkg::*;
#(
  parameter logic [7:0] SLOT_BUS  = 8'd0,
  parameter logic [4:0] SLOT_DEV  = 5'd2,
  parameter logic [2:0] SLOT_FUNC = 3'd0
) (
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              in_window,
  output logic              own_slot,
  output logic [WORD_W-1:0] word_idx
);
  cfg_addr_t f;
  logic      slot_eq;

  always_comb begin
    f         = split_addr(req_addr);
    slot_eq   = (f.bus == SLOT_BUS) && (f.dev == SLOT_DEV) && (f.func == SLOT_FUNC);
    in_window = req_vld && (f.window == WINDOW_NIB);
    own_slot  = in_window && slot_eq;
    word_idx  = f.word;
  end
endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
  import cfgdec_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1D5C,
  parameter logic [15:0] DEVICE_ID = 16'h0A01,
  parameter logic [15:0] CMD_WMASK = 16'h0007,
  parameter int          BAR_LSB   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] word_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);
  localparam int CMD_W  = 16;
  localparam int BASE_W = DATA_W - BAR_LSB;

  logic [CMD_W-1:0]  cmd_q;
  logic [BASE_W-1:0] base_q;
  logic              cmd_wr;
  logic              base_wr;

  assign cmd_wr  = wr_en && (word_idx == W_CMD);
  assign base_wr = wr_en && (word_idx == W_BASE);

  // one flop per writable command bit, constant zero elsewhere
  for (genvar i = 0; i < CMD_W; i++) begin : g_cmd
    if (CMD_WMASK[i]) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q[i] <= 1'b0;
        else if (cmd_wr) cmd_q[i] <= wdata[i];
      end
    end else begin : g_ro
      assign cmd_q[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= '0;
    else if (base_wr) base_q <= wdata[DATA_W-1:BAR_LSB];
  end

  always_comb begin
    unique case (word_idx)
      W_IDENT: rd_word = {DEVICE_ID, VENDOR_ID};
      W_CMD:   rd_word = {{(DATA_W-CMD_W){1'b0}}, cmd_q};
      W_BASE:  rd_word = {base_q, {BAR_LSB{1'b0}}};
      default: rd_word = '0;
    endcase
  end
endmodule

// File: rtl/cfg_timeout.sv
module cfg_timeout #(
  parameter int TMO_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_window,
  input  logic any_ack,
  output logic fire
);
  localparam int              CW   = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0]   LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fire  <= 1'b0;
    end else if (!in_window || any_ack) begin
      cnt_q <= '0;
      fire  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      fire  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      fire  <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_space_decoder.sv
module cfg_space_decoder
  import cfgdec_pkg::*;
#(
  parameter logic [7:0]  SLOT_BUS   = 8'd0,
  parameter logic [4:0]  SLOT_DEV   = 5'd2,
  parameter logic [2:0]  SLOT_FUNC  = 3'd0,
  parameter logic [15:0] VENDOR_ID  = 16'h1D5C,
  parameter logic [15:0] DEVICE_ID  = 16'h0A01,
  parameter logic [15:0] CMD_WMASK  = 16'h0007,
  parameter int          BAR_LSB    = 12,
  parameter int          TMO_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_we,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              ext_ack,
  output logic              cfg_sel,
  output logic              slot_hit,
  output logic              rsp_ack,
  output logic [31:0]       rsp_rdata
);
  logic [WORD_W-1:0] word_idx;
  logic [DATA_W-1:0] hdr_word;
  logic              accept;
  logic              ack_q;
  logic [DATA_W-1:0] rdata_q;
  logic              tmo_fire;

  cfg_addr_decode #(
    .SLOT_BUS (SLOT_BUS),
    .SLOT_DEV (SLOT_DEV),
    .SLOT_FUNC(SLOT_FUNC)
  ) u_dec (
    .req_vld  (req_vld),
    .req_addr (req_addr),
    .in_window(cfg_sel),
    .own_slot (slot_hit),
    .word_idx (word_idx)
  );

  // a held request is taken once; the ack cycle blocks a second take
  assign accept = slot_hit && !ack_q;

  cfg_header_regs #(
    .VENDOR_ID(VENDOR_ID),
    .DEVICE_ID(DEVICE_ID),
    .CMD_WMASK(CMD_WMASK),
    .BAR_LSB  (BAR_LSB)
  ) u_hdr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept && req_we),
    .word_idx(word_idx),
    .wdata   (req_wdata),
    .rd_word (hdr_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= accept;
      rdata_q <= (accept && !req_we) ? hdr_word : '0;
    end
  end

  cfg_timeout #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_window(cfg_sel),
    .any_ack  (ext_ack || rsp_ack),
    .fire     (tmo_fire)
  );

  assign rsp_ack   = ack_q || tmo_fire;
  assign rsp_rdata = tmo_fire ? {DATA_W{1'b1}} : rdata_q;
endmodule

// File: rtl/cfgdec_checks.sv
module cfgdec_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        req_vld,
  input logic [31:0] req_addr,
  input logic        ext_ack,
  input logic        cfg_sel,
  input logic        slot_hit,
  input logic        rsp_ack,
  input logic [31:0] rsp_rdata
);
  // R3
  own_ack_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_hit && !rsp_ack |=> rsp_ack);

  // R3
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack);

  // R8
  fallback_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack && !$past(slot_hit) |-> rsp_rdata == 32'hFFFF_FFFF);

  // R9
  ext_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack && !slot_hit |=> !rsp_ack);

  // R11
  outside_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && req_addr[31:28] != 4'hD |-> !cfg_sel && !slot_hit);

  // R11
  ack_from_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> $past(cfg_sel));
endmodule

bind cfg_space_decoder cfgdec_checks u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_vld  (req_vld),
  .req_addr (req_addr),
  .ext_ack  (ext_ack),
  .cfg_sel  (cfg_sel),
  .slot_hit (slot_hit),
  .rsp_ack  (rsp_ack),
  .rsp_rdata(rsp_rdata)
);

// File: tb/sim_cfg_space_decoder.sv
module sim_cfg_space_decoder;
  localparam logic [7:0]  BUS  = 8'h5A;
  localparam logic [4:0]  DEV  = 5'h13;
  localparam logic [2:0]  FUNC = 3'h5;
  localparam logic [15:0] VID  = 16'h1D5C;
  localparam logic [15:0] DID  = 16'h0A01;
  localparam logic [15:0] CMSK = 16'h0007;
  localparam int          TMO  = 16;
  localparam logic [31:0] BKEEP = 32'hFFFF_F000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0, req_we = 1'b0, ext_ack = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        cfg_sel, slot_hit, rsp_ack;
  logic [31:0] rsp_rdata;

  always #5 clk = ~clk;

  cfg_space_decoder #(
    .SLOT_BUS(BUS), .SLOT_DEV(DEV), .SLOT_FUNC(FUNC),
    .VENDOR_ID(VID), .DEVICE_ID(DID), .CMD_WMASK(CMSK),
    .BAR_LSB(12), .TMO_CYCLES(TMO)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .ext_ack(ext_ack),
    .cfg_sel(cfg_sel), .slot_hit(slot_hit), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R12";

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", t, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(logic [7:0] b, logic [4:0] d, logic [2:0] f, int w);
    return {4'hD, b, d, f, 10'(w), 2'b00};
  endfunction

  // behavioural reference: what the outputs should show after each edge
  bit          m_ack = 0;
  logic [31:0] m_data = '0;
  int          m_wait = 0;
  logic [15:0] m_cmd = '0;
  logic [31:0] m_bar = '0;

  function automatic logic [31:0] m_read(int w);
    if (w == 0) return {DID, VID};
    if (w == 1) return {16'h0, m_cmd};
    if (w == 4) return m_bar;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    bit          win, mine, nack;
    logic [31:0] nd;
    int          w;
    if (!rst_n) begin
      m_ack = 0; m_data = '0; m_wait = 0; m_cmd = '0; m_bar = '0;
    end else begin
      win  = req_vld && (req_addr[31:28] == 4'hD);
      mine = win && (req_addr[27:12] == {BUS, DEV, FUNC});
      w    = int'(req_addr[11:2]);
      nack = 0; nd = '0;
      if (mine && !m_ack) begin
        nack = 1;
        nd   = req_we ? 32'h0 : m_read(w);
        if (req_we && w == 1) m_cmd = req_wdata[15:0] & CMSK;
        if (req_we && w == 4) m_bar = req_wdata & BKEEP;
      end
      if (win && !ext_ack && !m_ack) begin
        m_wait++;
        if (m_wait == TMO) begin nack = 1; nd = 32'hFFFF_FFFF; m_wait = 0; end
      end else m_wait = 0;
      m_ack = nack; m_data = nd;
    end
  end

  // compare on every clock, away from the sampling edge
  always @(negedge clk) begin
    chk("R1", "cfg_sel", 32'(cfg_sel), 32'(req_vld && req_addr[31:28] == 4'hD));
    chk("R2", "slot_hit", 32'(slot_hit),
        32'(req_vld && req_addr[31:28] == 4'hD && req_addr[27:12] == {BUS, DEV, FUNC}));
    chk(tag, "rsp_ack", 32'(rsp_ack), 32'(m_ack));
    chk(tag, "rsp_rdata", rsp_rdata, m_data);
  end

  task automatic access(string t, bit we, logic [31:0] a, logic [31:0] wd,
                        bit cmp, logic [31:0] exp, int exp_lat);
    int n;
    tag = t;
    @(negedge clk); #2;
    req_vld = 1; req_we = we; req_addr = a; req_wdata = wd;
    n = 0;
    do begin @(negedge clk); n++; end while (!rsp_ack && n < 40);
    chk(t, "ack latency", 32'(n), 32'(exp_lat));
    if (cmp) chk(t, "read data", rsp_rdata, exp);
    #2 req_vld = 0; req_we = 0;
  endtask

  task automatic ext_answered(string t, logic [31:0] a, int dly);
    tag = t;
    @(negedge clk); #2;
    req_vld = 1; req_we = 0; req_addr = a;
    repeat (dly) @(negedge clk);
    #2 ext_ack = 1;
    @(negedge clk);
    chk(t, "no local ack", 32'(rsp_ack), 32'h0);
    #2 ext_ack = 0; req_vld = 0;
    repeat (TMO + 3) begin
      @(negedge clk);
      chk(t, "quiet after ext ack", 32'(rsp_ack), 32'h0);
    end
  endtask

  task automatic outside(string t, logic [31:0] a, int cyc);
    tag = t;
    @(negedge clk); #2;
    req_vld = 1; req_addr = a;
    repeat (cyc) begin
      @(negedge clk);
      chk(t, "no ack outside window", 32'(rsp_ack), 32'h0);
    end
    #2 req_vld = 0;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    chk("R12", "ack in reset", 32'(rsp_ack), 32'h0);
    chk("R12", "rdata in reset", rsp_rdata, 32'h0);
    #2 rst_n = 1;

    // R4 / R3: identification word from own slot
    access("R4", 0, mk(BUS, DEV, FUNC, 0), 0, 1, {DID, VID}, 1);
    // R5: command register masking and reset value
    access("R5", 0, mk(BUS, DEV, FUNC, 1), 0, 1, 32'h0, 1);
    access("R3", 1, mk(BUS, DEV, FUNC, 1), 32'hFFFF_FFFF, 1, 32'h0, 1);
    access("R5", 0, mk(BUS, DEV, FUNC, 1), 0, 1, 32'h0000_0007, 1);
    access("R5", 1, mk(BUS, DEV, FUNC, 1), 32'h0000_FFFA, 0, 0, 1);
    access("R5", 0, mk(BUS, DEV, FUNC, 1), 0, 1, 32'h0000_0002, 1);
    // R6: base address register
    access("R6", 0, mk(BUS, DEV, FUNC, 4), 0, 1, 32'h0, 1);
    access("R6", 1, mk(BUS, DEV, FUNC, 4), 32'hFFFF_FFFF, 0, 0, 1);
    access("R6", 0, mk(BUS, DEV, FUNC, 4), 0, 1, 32'hFFFF_F000, 1);
    access("R6", 1, mk(BUS, DEV, FUNC, 4), 32'h8001_2ABC, 0, 0, 1);
    access("R6", 0, mk(BUS, DEV, FUNC, 4), 0, 1, 32'h8001_2000, 1);
    // R7: read-only and reserved words
    access("R7", 1, mk(BUS, DEV, FUNC, 0), 32'h1234_5678, 0, 0, 1);
    access("R7", 0, mk(BUS, DEV, FUNC, 0), 0, 1, {DID, VID}, 1);
    access("R7", 1, mk(BUS, DEV, FUNC, 2), 32'hFFFF_FFFF, 0, 0, 1);
    access("R7", 0, mk(BUS, DEV, FUNC, 2), 0, 1, 32'h0, 1);
    access("R7", 0, mk(BUS, DEV, FUNC, 1023), 0, 1, 32'h0, 1);
    // R8: absent slots time out with all ones
    access("R8", 0, mk(BUS, DEV, 3'h4, 0), 0, 1, 32'hFFFF_FFFF, TMO);
    access("R8", 0, mk(8'h00, 5'h00, 3'h0, 0), 0, 1, 32'hFFFF_FFFF, TMO);
    access("R8", 0, mk(8'hA5, DEV, FUNC, 1), 0, 1, 32'hFFFF_FFFF, TMO);
    // R10: writes to absent slots change nothing here
    access("R10", 1, mk(BUS, 5'h12, FUNC, 1), 32'h0000_0005, 0, 0, TMO);
    access("R10", 1, mk(BUS, DEV, 3'h0, 4), 32'h0000_0000, 0, 0, TMO);
    access("R10", 0, mk(BUS, DEV, FUNC, 1), 0, 1, 32'h0000_0002, 1);
    access("R10", 0, mk(BUS, DEV, FUNC, 4), 0, 1, 32'h8001_2000, 1);
    // R9: another device answers before the timeout
    ext_answered("R9", mk(8'h01, 5'h02, 3'h0, 0), 3);
    ext_answered("R9", mk(8'h01, 5'h03, 3'h1, 0), TMO - 1);
    // R11: outside the window
    outside("R11", 32'hC000_0000, TMO + 6);
    outside("R11", 32'hE5A9_D000, TMO + 6);
    // R2: probe scan in 32 kB steps across neighbouring devices
    for (int d = 16; d < 22; d++) begin
      if (5'(d) == DEV)
        access("R2", 0, {4'hD, BUS, 5'(d), 3'h0, 12'h000}, 0, 1, 32'hFFFF_FFFF, TMO);
      else
        access("R2", 0, {4'hD, BUS, 5'(d), 3'h0, 12'h000}, 0, 1, 32'hFFFF_FFFF, TMO);
    end
    access("R2", 0, mk(BUS, DEV, FUNC, 0), 0, 1, {DID, VID}, 1);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule